// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block runs one I2C master transfer from a single 64-bit command word. It checks the command, loads two 16-bit residual counters with the transfer length, and asks a byte-level bus engine for a start with the device address. It then moves bytes between that engine and an internal FIFO, one byte per cycle at most. When the bus side and the host side have both finished, it reports completion and can ask the engine for a stop. The engine handles bit timing on SCL and SDA and is outside this block. The engine reports a NACK in the same cycle as the start or send request that caused it, and returns received data in the same cycle as the receive request.

The host fills the FIFO for a write and drains it for a read through push and pop strobes. The bus-side counter tracks bytes that have crossed the bus, and the host-side counter tracks bytes the host has moved. A mode write selects the target port. Two soft-reset strobes are provided: one clears only the error state of a transfer, and the other returns the whole block to its reset state.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, `cmd_done` is 1, all error flags are 0, the FIFO is empty, the bus is idle, both residual counters are 0, `cap_fifo_size` reads 8 and `cap_version` reads 23.
- R2: Command bits are numbered MSB-first, so command bit k is `cmd_word[63-k]`. Bit 0 requests a start, bit 1 requests an address phase, bit 2 is read-continue (stored, no effect), bit 3 requests a stop, bits 8..14 hold the 7-bit device address, bit 15 selects a read when 1, and bits 16..31 hold the 16-bit length.
- R3: A command with start, address and stop all 0 and a length of 0 sets `err_invalid` and changes nothing else.
- R4: A length above 0xFFF0 sets `err_invalid` and is not accepted. A length of exactly 0xFFF0 is accepted.
- R5: A command written while `cmd_done` is 0 sets `err_invalid`, and both residual counters keep their values.
- R6: An accepted command loads both residual counters with its length in the next cycle. If it requests a start, `cmd_done` falls and `eng_start` is high for one cycle in that next cycle, carrying the address and direction.
- R7: A NACK on the start sets `err_nack`, sets `cmd_done` back to 1 and leaves the bus idle.
- R8: In a write, each host push decrements the host-side counter. Each byte the engine sends decrements the bus-side counter. The engine sends at most one byte per cycle and stalls while the FIFO is empty.
- R9: In a read, the engine receives at most one byte per cycle into the FIFO and stalls at 8 entries while the FIFO is full. Host pops return the bytes in the order they were received and decrement the host-side counter.
- R10: One cycle after both counters reach 0, `cmd_done` rises and `data_req` is 0. If a stop was requested, `eng_stop` pulses in the following cycle and the bus then goes idle. Without a stop request, the bus stays busy.
- R11: A NACK on a sent byte sets `err_nack`, is followed by a stop, and leaves `cmd_done` at 0. Further commands are then rejected until an error reset.
- R12: A mode write while the bus is busy sets `err_invalid`. A port number at or above the port count (4) makes commands do nothing. `port_busy` has bit p set only while port p is busy.
- R13: A push outside a write, or a pop outside a read, sets `err_invalid`. A pop from an empty FIFO during a read sets `err_overrun`.
- R14: `err_rst` clears the errors, both counters and the FIFO, idles the bus and sets `cmd_done`. `soft_rst` does the same and also returns the selected port to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | 64 | Command word |
| mode_we | input | 1 | Mode write strobe |
| mode_port | input | PORT_W | Port number to select |
| soft_rst | input | 1 | Full soft reset |
| err_rst | input | 1 | Error and transfer reset |
| host_push | input | 1 | Host writes a byte into the FIFO |
| host_wdata | input | 8 | Byte to push |
| host_pop | input | 1 | Host takes a byte from the FIFO |
| host_rdata | output | 8 | Last popped byte |
| eng_start | output | 1 | Engine: start and address phase |
| eng_addr | output | 7 | Engine: device address |
| eng_rnw | output | 1 | Engine: 1 for read |
| eng_send | output | 1 | Engine: send one byte |
| eng_txd | output | 8 | Engine: byte to send |
| eng_recv | output | 1 | Engine: receive one byte |
| eng_rxd | input | 8 | Engine: received byte |
| eng_nack | input | 1 | Engine: NACK on start or send |
| eng_stop | output | 1 | Engine: issue a stop |
| cmd_done | output | 1 | Command complete |
| data_req | output | 1 | Host service wanted |
| err_invalid | output | 1 | Invalid command or access |
| err_nack | output | 1 | NACK received |
| err_overrun | output | 1 | Pop from an empty FIFO |
| bus_busy | output | 1 | Transfer holds the bus |
| port_busy | output | NPORTS | Busy bit for each port |
| fifo_level | output | CW | FIFO entry count |
| resid_bus | output | 16 | Bus-side residual |
| resid_host | output | 16 | Host-side residual |
| cap_fifo_size | output | 8 | FIFO size |
| cap_version | output | 5 | Version |

## Verification
The assertions assume that strobes arrive one at a time. They also assume the engine raises `eng_nack` only in a cycle with `eng_start` or `eng_send` active. The bench meets both assumptions: it drives each command, mode write, push, pop and reset strobe on its own for one cycle. Its engine model derives the NACK from those two requests and from a per-test flag, so a NACK never appears in any other cycle.

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int DEPTH   = 8,
  parameter int NPORTS  = 4,
  parameter int PORT_W  = 6,
  parameter int VERSION = 23,
  parameter logic [15:0] MAX_LEN = 16'hFFF0,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [63:0]       cmd_word,
  input  logic              mode_we,
  input  logic [PORT_W-1:0] mode_port,
  input  logic              soft_rst,
  input  logic              err_rst,
  input  logic              host_push,
  input  logic [7:0]        host_wdata,
  input  logic              host_pop,
  output logic [7:0]        host_rdata,
  output logic              eng_start,
  output logic [6:0]        eng_addr,
  output logic              eng_rnw,
  output logic              eng_send,
  output logic [7:0]        eng_txd,
  output logic              eng_recv,
  input  logic [7:0]        eng_rxd,
  input  logic              eng_nack,
  output logic              eng_stop,
  output logic              cmd_done,
  output logic              data_req,
  output logic              err_invalid,
  output logic              err_nack,
  output logic              err_overrun,
  output logic              bus_busy,
  output logic [NPORTS-1:0] port_busy,
  output logic [CW-1:0]     fifo_level,
  output logic [15:0]       resid_bus,
  output logic [15:0]       resid_host,
  output logic [7:0]        cap_fifo_size,
  output logic [4:0]        cap_version
);

  typedef enum logic [1:0] {S_IDLE, S_START, S_XFER, S_STOP} st_t;

  st_t              st;
  logic [PORT_W-1:0] port_q, bport_q;
  logic [6:0]       addr_q;
  logic             rnw_q, stop_q, rcont_q;
  logic [15:0]      rb_q, rh_q;
  logic             done_q, inv_q, nack_q, ovr_q;
  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic [7:0]       rdata_q;

  wire        c_start = cmd_word[63];
  wire        c_addr  = cmd_word[62];
  wire        c_rcont = cmd_word[61];
  wire        c_stop  = cmd_word[60];
  wire [6:0]  c_dev   = cmd_word[55:49];
  wire        c_rnw   = cmd_word[48];
  wire [15:0] c_len   = cmd_word[47:32];
  wire        unused_bits = &{1'b0, cmd_word[59:56], cmd_word[31:0], rcont_q};

  wire port_ok = port_q < PORT_W'(NPORTS);
  wire c_empty = !c_start && !c_addr && !c_stop && (c_len == 16'd0);
  wire cmd_bad = cmd_we && (c_empty || (c_len > MAX_LEN) || !done_q);
  wire cmd_ok  = cmd_we && !cmd_bad && port_ok;
  wire quiet   = !soft_rst && !err_rst && !cmd_we;
  wire xfer    = (st == S_XFER);
  wire full    = (cnt == CW'(DEPTH));
  wire empty   = (cnt == '0);
  wire finishing = xfer && !done_q && (rb_q == 16'd0) && (rh_q == 16'd0);

  wire wr_path = xfer && !rnw_q && (rh_q != 16'd0);
  wire rd_path = xfer &&  rnw_q && (rh_q != 16'd0);
  wire h_push  = quiet && host_push && wr_path && !full;
  wire h_pop   = quiet && host_pop  && rd_path && !empty;
  wire h_inv   = quiet && ((host_push && !wr_path) || (host_pop && !rd_path));
  wire h_ovr   = quiet && host_pop && rd_path && empty;

  assign eng_start = (st == S_START);
  assign eng_stop  = (st == S_STOP);
  assign eng_send  = quiet && xfer && !rnw_q && (rb_q != 16'd0) && !empty;
  assign eng_recv  = quiet && xfer &&  rnw_q && (rb_q != 16'd0) && !full;
  assign eng_addr  = addr_q;
  assign eng_rnw   = rnw_q;
  assign eng_txd   = mem[rp];

  wire push_en = h_push || eng_recv;
  wire pop_en  = h_pop  || eng_send;
  wire [7:0] push_data = rnw_q ? eng_rxd : host_wdata;

  assign bus_busy    = xfer || (st == S_STOP);
  assign cmd_done    = done_q;
  assign err_invalid = inv_q;
  assign err_nack    = nack_q;
  assign err_overrun = ovr_q;
  assign fifo_level  = cnt;
  assign resid_bus   = rb_q;
  assign resid_host  = rh_q;
  assign host_rdata  = rdata_q;
  assign data_req    = xfer && !done_q && (rnw_q ? !empty : ((rh_q != 16'd0) && !full));
  assign cap_fifo_size = 8'(DEPTH);
  assign cap_version   = 5'(VERSION);

  for (genvar p = 0; p < NPORTS; p++) begin : g_pbusy
    assign port_busy[p] = bus_busy && (bport_q == PORT_W'(p));
  end

  always_ff @(posedge clk) begin
    if (push_en) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; port_q <= '0; bport_q <= '0; addr_q <= '0;
      rnw_q <= 1'b0; stop_q <= 1'b0; rcont_q <= 1'b0;
      rb_q <= '0; rh_q <= '0; done_q <= 1'b1;
      inv_q <= 1'b0; nack_q <= 1'b0; ovr_q <= 1'b0;
      wp <= '0; rp <= '0; cnt <= '0; rdata_q <= '0;
    end else if (soft_rst || err_rst) begin
      st <= S_IDLE; rb_q <= '0; rh_q <= '0; done_q <= 1'b1;
      inv_q <= 1'b0; nack_q <= 1'b0; ovr_q <= 1'b0;
      wp <= '0; rp <= '0; cnt <= '0;
      if (soft_rst) port_q <= '0;
    end else begin
      if (cmd_bad || h_inv || (mode_we && bus_busy)) inv_q <= 1'b1;
      if (h_ovr) ovr_q <= 1'b1;
      if (mode_we) port_q <= mode_port;

      if (cmd_ok) begin
        rb_q <= c_len; rh_q <= c_len;
        addr_q <= c_dev; rnw_q <= c_rnw; stop_q <= c_stop; rcont_q <= c_rcont;
        if (c_start) begin
          done_q <= 1'b0;
          st <= S_START;
        end
      end else begin
        unique case (st)
          S_START: begin
            bport_q <= port_q;
            if (eng_nack) begin
              nack_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
            end else st <= S_XFER;
          end
          S_XFER: begin
            if (finishing) begin
              done_q <= 1'b1;
              if (stop_q) st <= S_STOP;
            end
            if (eng_send && eng_nack) begin
              nack_q <= 1'b1; st <= S_STOP;
            end
          end
          S_STOP:  st <= S_IDLE;
          default: ;
        endcase
      end

      if (eng_send || eng_recv) rb_q <= rb_q - 16'd1;
      if (h_push || h_pop) rh_q <= rh_q - 16'd1;
      if (push_en) wp <= wp + AW'(1);
      if (pop_en) rp <= rp + AW'(1);
      if (h_pop) rdata_q <= mem[rp];
      cnt <= cnt + CW'(push_en) - CW'(pop_en);
    end
  end

  p_one_engine_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_start, eng_send, eng_recv, eng_stop}));

  p_bus_resid_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we && !soft_rst && !err_rst) |=>
      (rb_q == $past(rb_q) || rb_q == $past(rb_q) - 16'd1));

  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(DEPTH));

  p_done_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !data_req);

  p_stop_frees_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop |=> !bus_busy);

  p_send_nack_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_send && eng_nack) |=> (eng_stop && !cmd_done));

  p_start_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && c_start && !soft_rst && !err_rst) |=> eng_start);

  p_port_busy_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_busy));

endmodule

// File: tb/i2c_cmd_seq_tb_top.sv
module i2c_cmd_seq_tb_top;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cmd_we = 0, mode_we = 0, soft_rst = 0, err_rst = 0, host_push = 0, host_pop = 0;
  logic [63:0] cmd_word = '0;
  logic [5:0]  mode_port = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata, eng_txd, eng_rxd;
  logic        eng_start, eng_rnw, eng_send, eng_recv, eng_nack, eng_stop;
  logic [6:0]  eng_addr;
  logic        cmd_done, data_req, err_invalid, err_nack, err_overrun, bus_busy;
  logic [3:0]  port_busy;
  logic [CW-1:0] fifo_level;
  logic [15:0] resid_bus, resid_host;
  logic [7:0]  cap_fifo_size;
  logic [4:0]  cap_version;

  logic nack_addr = 0, nack_byte = 0;
  assign eng_nack = (eng_start && nack_addr) || (eng_send && nack_byte);

  int rx_cnt = 0, tx_cnt = 0, start_cnt = 0, stop_cnt = 0, cyc = 0;
  logic [7:0] tx_log [0:63];
  assign eng_rxd = 8'hA0 + rx_cnt[7:0];

  i2c_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .mode_we(mode_we), .mode_port(mode_port), .soft_rst(soft_rst), .err_rst(err_rst),
    .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
    .eng_start(eng_start), .eng_addr(eng_addr), .eng_rnw(eng_rnw), .eng_send(eng_send),
    .eng_txd(eng_txd), .eng_recv(eng_recv), .eng_rxd(eng_rxd), .eng_nack(eng_nack),
    .eng_stop(eng_stop), .cmd_done(cmd_done), .data_req(data_req), .err_invalid(err_invalid),
    .err_nack(err_nack), .err_overrun(err_overrun), .bus_busy(bus_busy), .port_busy(port_busy),
    .fifo_level(fifo_level), .resid_bus(resid_bus), .resid_host(resid_host),
    .cap_fifo_size(cap_fifo_size), .cap_version(cap_version));

  int n_chk = 0, n_err = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (eng_recv) rx_cnt <= rx_cnt + 1;
    if (eng_send) begin tx_log[tx_cnt[5:0]] <= eng_txd; tx_cnt <= tx_cnt + 1; end
    if (eng_start) start_cnt <= start_cnt + 1;
    if (eng_stop) stop_cnt <= stop_cnt + 1;
    if (cyc == 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung (act=%0d exp<%0d cycles)", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  function automatic logic [63:0] mk(input bit st, input bit ad, input bit sp,
                                     input logic [6:0] dev, input bit rd, input logic [15:0] len);
    logic [63:0] w = '0;
    w[63] = st; w[62] = ad; w[60] = sp; w[55:49] = dev; w[48] = rd; w[47:32] = len;
    return w;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [63:0] w);
    cmd_word = w; cmd_we = 1; @(negedge clk); cmd_we = 0;
  endtask

  task automatic push(input logic [7:0] b);
    host_wdata = b; host_push = 1; @(negedge clk); host_push = 0;
  endtask

  task automatic pop();
    host_pop = 1; @(negedge clk); host_pop = 0;
  endtask

  task automatic set_port(input logic [5:0] p);
    mode_port = p; mode_we = 1; @(negedge clk); mode_we = 0;
  endtask

  task automatic clr_err();
    err_rst = 1; @(negedge clk); err_rst = 0;
  endtask

  task automatic t_reset();
    eq("R1", "cmd_done", cmd_done, 1);
    eq("R1", "errors", {err_invalid, err_nack, err_overrun}, 0);
    eq("R1", "fifo_size", cap_fifo_size, 8);
    eq("R1", "version", cap_version, 23);
    eq("R1", "level/busy", {fifo_level, bus_busy}, 0);
    eq("R1", "residuals", {resid_bus, resid_host}, 0);
  endtask

  task automatic t_invalid();
    int s0 = start_cnt;
    send_cmd(mk(0, 0, 0, 7'h10, 0, 16'd0));
    eq("R3", "empty cmd invalid", err_invalid, 1);
    eq("R3", "residual untouched", resid_bus, 0);
    clr_err();
    send_cmd(mk(1, 1, 1, 7'h10, 0, 16'hFFF1));
    idle(1);
    eq("R4", "long len invalid", err_invalid, 1);
    eq("R4", "no start for long len", start_cnt - s0, 0);
    clr_err();
    send_cmd(mk(0, 1, 0, 7'h10, 0, 16'hFFF0));
    eq("R4", "max len accepted", resid_bus, 16'hFFF0);
    eq("R4", "max len no error", err_invalid, 0);
    clr_err();
  endtask

  task automatic t_write();
    int s0 = start_cnt, p0 = stop_cnt, t0 = tx_cnt;
    send_cmd(mk(1, 1, 1, 7'h52, 0, 16'd3));
    eq("R6", "bus residual load", resid_bus, 3);
    eq("R6", "host residual load", resid_host, 3);
    eq("R6", "done falls", cmd_done, 0);
    eq("R2", "start with addr/dir", {eng_start, eng_addr, eng_rnw}, {1'b1, 7'h52, 1'b0});
    idle(3);
    eq("R8", "stall on empty", tx_cnt - t0, 0);
    eq("R8", "resid held", resid_bus, 3);
    eq("R12", "port 0 busy", port_busy, 4'b0001);
    eq("R8", "data_req", data_req, 1);
    push(8'h11);
    eq("R8", "host residual dec", resid_host, 2);
    push(8'h22); push(8'h33);
    idle(5);
    eq("R8", "bytes sent", tx_cnt - t0, 3);
    eq("R8", "byte order", {tx_log[t0], tx_log[t0+1], tx_log[t0+2]}, 24'h112233);
    eq("R10", "done", cmd_done, 1);
    eq("R10", "no data_req", data_req, 0);
    eq("R10", "one stop", stop_cnt - p0, 1);
    eq("R10", "bus idle", bus_busy, 0);
    eq("R6", "one start", start_cnt - s0, 1);
  endtask

  task automatic t_read();
    int r0 = rx_cnt, p0 = stop_cnt;
    send_cmd(mk(1, 1, 1, 7'h30, 1, 16'd10));
    eq("R2", "read dir", {eng_start, eng_addr, eng_rnw}, {1'b1, 7'h30, 1'b1});
    idle(14);
    eq("R9", "fifo full stall", fifo_level, 8);
    eq("R9", "bus residual", resid_bus, 2);
    eq("R9", "received", rx_cnt - r0, 8);
    for (int i = 0; i < 10; i++) begin
      pop();
      eq("R9", "pop data", host_rdata, 8'(8'hA0 + r0 + i));
    end
    idle(3);
    eq("R9", "host residual", resid_host, 0);
    eq("R10", "read done", cmd_done, 1);
    eq("R10", "read stop", stop_cnt - p0, 1);
  endtask

  task automatic t_hold();
    int p0 = stop_cnt;
    send_cmd(mk(1, 1, 0, 7'h21, 0, 16'd1));
    idle(1);
    push(8'h5A);
    idle(4);
    eq("R10", "done without stop", cmd_done, 1);
    eq("R10", "bus held", bus_busy, 1);
    eq("R10", "no stop", stop_cnt - p0, 0);
    eq("R12", "clean before mode", err_invalid, 0);
    set_port(6'd1);
    eq("R12", "mode while busy", err_invalid, 1);
    clr_err();
    eq("R14", "err reset", {err_invalid, bus_busy, cmd_done}, 3'b001);
    set_port(6'd0);
  endtask

  task automatic t_reject();
    send_cmd(mk(1, 1, 1, 7'h22, 0, 16'd2));
    send_cmd(mk(1, 1, 1, 7'h23, 0, 16'd9));
    eq("R5", "busy reject flag", err_invalid, 1);
    eq("R5", "residuals kept", {resid_bus, resid_host}, {16'd2, 16'd2});
    push(8'h01); push(8'h02);
    idle(5);
    eq("R5", "first cmd finished", cmd_done, 1);
    clr_err();
  endtask

  task automatic t_nack_addr();
    int p0 = stop_cnt;
    nack_addr = 1;
    send_cmd(mk(1, 1, 1, 7'h44, 0, 16'd2));
    idle(1);
    nack_addr = 0;
    eq("R7", "nack flag", err_nack, 1);
    eq("R7", "done back", cmd_done, 1);
    eq("R7", "bus idle", bus_busy, 0);
    eq("R7", "no stop", stop_cnt - p0, 0);
    clr_err();
  endtask

  task automatic t_nack_byte();
    int p0 = stop_cnt, s0;
    send_cmd(mk(1, 1, 1, 7'h45, 0, 16'd2));
    idle(1);
    nack_byte = 1;
    push(8'h99);
    idle(3);
    nack_byte = 0;
    eq("R11", "nack flag", err_nack, 1);
    eq("R11", "stop issued", stop_cnt - p0, 1);
    eq("R11", "bus idle", bus_busy, 0);
    eq("R11", "done stays low", cmd_done, 0);
    s0 = start_cnt;
    send_cmd(mk(1, 1, 1, 7'h45, 0, 16'd1));
    idle(1);
    eq("R11", "later cmd rejected", {err_invalid, 8'(start_cnt - s0)}, {1'b1, 8'd0});
    clr_err();
    eq("R14", "err reset done", {cmd_done, err_nack}, 2'b10);
  endtask

  task automatic t_port();
    int s0 = start_cnt;
    set_port(6'd5);
    send_cmd(mk(1, 1, 1, 7'h11, 0, 16'd4));
    idle(2);
    eq("R12", "bad port no start", start_cnt - s0, 0);
    eq("R12", "bad port no load", resid_bus, 0);
    set_port(6'd2);
    send_cmd(mk(1, 1, 1, 7'h12, 1, 16'd1));
    idle(2);
    eq("R12", "port 2 busy", port_busy, 4'b0100);
    pop();
    idle(3);
    eq("R12", "port free", port_busy, 0);
    set_port(6'd0);
  endtask

  task automatic t_host_err();
    pop();
    eq("R13", "pop idle invalid", err_invalid, 1);
    clr_err();
    send_cmd(mk(1, 1, 1, 7'h13, 1, 16'd2));
    idle(1);
    pop();
    eq("R13", "pop empty overrun", err_overrun, 1);
    push(8'h77);
    eq("R13", "push in read invalid", err_invalid, 1);
    clr_err();
    eq("R14", "fifo cleared", fifo_level, 0);
  endtask

  task automatic t_soft();
    int s0, p0, t0;
    set_port(6'd5);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    s0 = start_cnt; p0 = stop_cnt; t0 = tx_cnt;
    send_cmd(mk(1, 0, 1, 7'h14, 0, 16'd0));
    idle(5);
    eq("R14", "port back to 0", start_cnt - s0, 1);
    eq("R10", "zero len stop", stop_cnt - p0, 1);
    eq("R10", "zero len no bytes", tx_cnt - t0, 0);
    eq("R10", "zero len done", cmd_done, 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_invalid();
    t_write();
    t_read();
    t_hold();
    t_reject();
    t_nack_addr();
    t_nack_byte();
    t_port();
    t_host_err();
    t_soft();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule